// File: doc/BRIEF.md
# DMA-Aware Interrupt Aggregator

This block gathers a parameterised set of interrupt request lines (32 by default) into one level-sensitive interrupt for a processor. Each line has a sticky pending bit that is set on a rising edge of its source. It also has an enable bit, and the processor interrupt is asserted while any pending bit is also enabled. Software reaches the pending and enable registers through a simple register port. Reads return data one cycle after the request.

The lowest `DMA_BASE` lines are ordinary device interrupts. The lines from `DMA_BASE` up to the top are DMA interrupts, and a constant class vector `INFO_MASK` sorts them into two kinds. An informational DMA event only raises a pending bit and may fire again once it is cleared. An error DMA event also asserts a halt signal for its channel. That halt stays high until software clears the pending bit, so the event cannot fire again while it is outstanding.

Software clears pending bits by writing zeros. Each bit written as 1 is left alone, so one source can be cleared without a read-modify-write race against the other sources.

Top module: `irq_aggregator`

## Requirements
- R1: A rising edge on `irqReq[i]` sets pending bit i at that clock edge, even when enable bit i is 0. A source that stays high does not produce another edge.
- R2: A source held high after its pending bit has been cleared does not set the bit again. A new low-to-high transition is needed.
- R3: A write to the pending register (address 0) clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R4: If a rising edge and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: A write to the enable register (address 1) replaces its whole contents. A read of address 1 returns the value last written.
- R6: `cpuIrq` is high in exactly the cycles where some pending bit has its enable bit set. Enabling a line that is already pending raises `cpuIrq` in the cycle after the write.
- R7: After reset the pending and enable registers are all zero and `cpuIrq` is low.
- R8: For a DMA line `DMA_BASE+k` whose `INFO_MASK` bit is 0 (error class), `dmaHalt[k]` equals its pending bit whatever its enable bit. The halt stays high until a write to address 0 clears that bit.
- R9: `dmaHalt[k]` is always low for an informational DMA line (`INFO_MASK` bit 1). Such a line sets its pending bit again on a new edge after it has been cleared. Lines below `DMA_BASE` never drive any halt.
- R10: A read with `regRdEn` high returns the pending register (address 0) or the enable register (address 1) on `regRdData` in the next cycle, with `regRdValid` high for that one cycle. The value returned is the one before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqReq | input | NUM_LINES | Interrupt request sources, edge-detected |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 1 | 0 = pending register, 1 = enable register |
| regWrData | input | NUM_LINES | Write data |
| regRdData | output | NUM_LINES | Read data, valid one cycle after the request |
| regRdValid | output | 1 | High in the cycle that regRdData carries read data |
| cpuIrq | output | 1 | Level-sensitive processor interrupt |
| dmaHalt | output | NUM_LINES-DMA_BASE | Per-channel DMA stop for error-class lines |

## Verification
The assertions check on every cycle the rules that look at the cycle just before: a rising edge leaves its bit set, even against a clearing write; a zero write drops the bits it names; an error halt cannot fall without a clearing write; `cpuIrq` stays low while nothing is enabled; and reads complete in one cycle. Other behaviours only show up over a sequence of cycles, and only the bench scenarios cover them. These include a held source that never re-sets its bit, an informational line firing again after it is cleared, and an already-pending line raising the interrupt as soon as it is enabled. A behavioural model in the bench follows all of these on every clock, through directed cases and a long random mix.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef enum logic {
    ADDR_PENDING = 1'b0,
    ADDR_ENABLE  = 1'b1
  } regAddrT;

  typedef struct packed {
    logic wrPending;
    logic wrEnable;
    logic rdPending;
    logic rdEnable;
  } regStrobeT;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      regWrEn,
  input  logic      regRdEn,
  input  logic      regAddr,
  output regStrobeT strobes,
  output logic      rdValid
);

  regAddrT addrSel;

  assign addrSel = regAddrT'(regAddr);

  always_comb begin
    strobes.wrPending = regWrEn && (addrSel == ADDR_PENDING);
    strobes.wrEnable  = regWrEn && (addrSel == ADDR_ENABLE);
    strobes.rdPending = regRdEn && (addrSel == ADDR_PENDING);
    strobes.rdEnable  = regRdEn && (addrSel == ADDR_ENABLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= regRdEn;
  end

endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DMA_BASE  = 16,
  parameter logic [NUM_LINES-1:0] INFO_MASK = '0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  regStrobeT                     strobes,
  input  logic [NUM_LINES-1:0]          irqReq,
  input  logic [NUM_LINES-1:0]          wrData,
  output logic [NUM_LINES-1:0]          rdData,
  output logic                          cpuIrq,
  output logic [NUM_LINES-DMA_BASE-1:0] dmaHalt
);

  localparam int NUM_DMA = NUM_LINES - DMA_BASE;

  logic [NUM_LINES-1:0] reqPrevQ;
  logic [NUM_LINES-1:0] statusQ;
  logic [NUM_LINES-1:0] maskQ;
  logic [NUM_LINES-1:0] riseVec;
  logic [NUM_LINES-1:0] keepVec;

  // edge detection on the request sources
  assign riseVec = irqReq & ~reqPrevQ;
  // zero bits of a pending write clear, ones keep
  assign keepVec = strobes.wrPending ? wrData : '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPrevQ <= '0;
      statusQ  <= '0;
      maskQ    <= '0;
    end else begin
      reqPrevQ <= irqReq;
      statusQ  <= (statusQ & keepVec) | riseVec;  // set beats clear
      if (strobes.wrEnable) maskQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobes.rdEnable) begin
      rdData <= maskQ;
    end else if (strobes.rdPending) begin
      rdData <= statusQ;
    end
  end

  assign cpuIrq = |(statusQ & maskQ);

  for (genvar k = 0; k < NUM_DMA; k++) begin : g_halt
    if (INFO_MASK[DMA_BASE+k]) begin : g_info
      assign dmaHalt[k] = 1'b0;
    end else begin : g_err
      assign dmaHalt[k] = statusQ[DMA_BASE+k];
    end
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DMA_BASE  = 16,
  parameter logic [NUM_LINES-1:0] INFO_MASK = 32'h5555_0000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_LINES-1:0]          irqReq,
  input  logic                          regWrEn,
  input  logic                          regRdEn,
  input  logic                          regAddr,
  input  logic [NUM_LINES-1:0]          regWrData,
  output logic [NUM_LINES-1:0]          regRdData,
  output logic                          regRdValid,
  output logic                          cpuIrq,
  output logic [NUM_LINES-DMA_BASE-1:0] dmaHalt
);

  regStrobeT strobes;

  irq_agg_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strobes (strobes),
    .rdValid (regRdValid)
  );

  irq_agg_datapath #(
    .NUM_LINES (NUM_LINES),
    .DMA_BASE  (DMA_BASE),
    .INFO_MASK (INFO_MASK)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .irqReq  (irqReq),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .cpuIrq  (cpuIrq),
    .dmaHalt (dmaHalt)
  );

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int NUM_LINES = 32,
  parameter int DMA_BASE  = 16
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [NUM_LINES-1:0]          irqReq,
  input logic                          regWrEn,
  input logic                          regRdEn,
  input logic                          regAddr,
  input logic [NUM_LINES-1:0]          regWrData,
  input logic                          regRdValid,
  input logic                          cpuIrq,
  input logic [NUM_LINES-DMA_BASE-1:0] dmaHalt,
  input logic [NUM_LINES-1:0]          statusQ,
  input logic [NUM_LINES-1:0]          maskQ,
  input logic [NUM_LINES-1:0]          reqPrevQ
);

  logic                          pastOk;
  logic [NUM_LINES-1:0]          riseV;
  logic [NUM_LINES-1:0]          clrV;
  logic [NUM_LINES-DMA_BASE-1:0] clrDma;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  assign riseV  = irqReq & ~reqPrevQ;
  assign clrV   = (regWrEn && !regAddr) ? ~regWrData : '0;
  assign clrDma = clrV[NUM_LINES-1:DMA_BASE];

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |=> ((statusQ & $past(riseV)) == $past(riseV))); // R1

  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |=> ((statusQ & $past(clrV & ~riseV)) == '0)); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && (|(clrV & riseV))) |=> ((statusQ & $past(clrV & riseV)) == $past(clrV & riseV))); // R4

  AST_NO_ENABLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !cpuIrq); // R6

  AST_RESET_EMPTY: assert property (@(posedge clk)
    $rose(rstN) |-> ((statusQ == '0) && (maskQ == '0) && !cpuIrq)); // R7

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |=> ((dmaHalt & $past(dmaHalt & ~clrDma)) == $past(dmaHalt & ~clrDma))); // R8

  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> regRdValid); // R10

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !regRdEn) |=> !regRdValid); // R10

endmodule

bind irq_aggregator irq_aggregator_chk #(
  .NUM_LINES (NUM_LINES),
  .DMA_BASE  (DMA_BASE)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .irqReq     (irqReq),
  .regWrEn    (regWrEn),
  .regRdEn    (regRdEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .regRdValid (regRdValid),
  .cpuIrq     (cpuIrq),
  .dmaHalt    (dmaHalt),
  .statusQ    (dp_i.statusQ),
  .maskQ      (dp_i.maskQ),
  .reqPrevQ   (dp_i.reqPrevQ)
);

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;

  localparam int NL = 32;
  localparam int DB = 16;
  localparam int ND = NL - DB;
  localparam logic [NL-1:0] INFO = 32'h5555_0000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NL-1:0] reqV = '0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic          addr = 1'b0;
  logic [NL-1:0] wdata = '0;
  logic [NL-1:0] rdData;
  logic          rdValid;
  logic          irq;
  logic [ND-1:0] halt;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [NL-1:0] mStatus = '0;
  logic [NL-1:0] mMask = '0;
  logic [NL-1:0] mPrev = '0;
  logic [NL-1:0] mRd = '0;
  logic          mRdV = 1'b0;

  always #5 clk = ~clk;

  irq_aggregator #(.NUM_LINES(NL), .DMA_BASE(DB), .INFO_MASK(INFO)) dut_i (
    .clk(clk), .rstN(rstN), .irqReq(reqV), .regWrEn(wrEn), .regRdEn(rdEn),
    .regAddr(addr), .regWrData(wdata), .regRdData(rdData), .regRdValid(rdValid),
    .cpuIrq(irq), .dmaHalt(halt)
  );

  function automatic logic [ND-1:0] expHalt();
    logic [ND-1:0] h = '0;
    for (int k = 0; k < ND; k++) if (!INFO[DB+k]) h[k] = mStatus[DB+k];
    return h;
  endfunction

  task automatic check(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: update the model at the edge, compare away from it
  task automatic step();
    logic [NL-1:0] rise;
    @(posedge clk);
    rise = reqV & ~mPrev;
    if (rdEn) mRd = addr ? mMask : mStatus;
    mRdV = rdEn;
    if (wrEn && !addr) mStatus = mStatus & wdata;
    if (wrEn && addr) mMask = wdata;
    mStatus = mStatus | rise;
    mPrev = reqV;
    @(negedge clk);
    check("R6 cpuIrq", NL'(irq), NL'(|(mStatus & mMask)));
    check("R8 dmaHalt", NL'(halt), NL'(expHalt()));
    check("R10 rdValid", NL'(rdValid), NL'(mRdV));
    if (mRdV) check("R10 rdData", rdData, mRd);
  endtask

  task automatic wrReg(input logic a, input logic [NL-1:0] d);
    wrEn = 1'b1; addr = a; wdata = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic rdCheck(input logic a, input logic [NL-1:0] exp, input string tag);
    rdEn = 1'b1; addr = a;
    step();
    rdEn = 1'b0;
    check(tag, rdData, exp);
  endtask

  task automatic pulse(input int line);
    reqV[line] = 1'b1;
    step();
    reqV[line] = 1'b0;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R7: reset state
    check("R7 irq after reset", NL'(irq), '0);
    rdCheck(1'b0, '0, "R7 pending after reset");
    rdCheck(1'b1, '0, "R7 enable after reset");

    // R1: edge latches while disabled
    pulse(3);
    rdCheck(1'b0, NL'(1) << 3, "R1 masked edge latched");
    check("R1 no irq while disabled", NL'(irq), '0);

    // R6: enabling a pending line raises irq next cycle
    wrReg(1'b1, NL'(1) << 3);
    check("R6 irq on enable", NL'(irq), NL'(1));

    // R2/R3: held source does not re-set; ones keep other bits
    pulse(5);
    reqV[3] = 1'b1;
    step();
    wrReg(1'b0, ~(NL'(1) << 3));
    repeat (4) step();
    rdCheck(1'b0, NL'(1) << 5, "R2 R3 held source stays cleared");
    check("R3 irq dropped", NL'(irq), '0);
    reqV[3] = 1'b0;
    step();

    // R4: set beats clear in the same cycle
    reqV[7] = 1'b1;
    wrReg(1'b0, ~((NL'(1) << 7) | (NL'(1) << 5)));
    reqV[7] = 1'b0;
    rdCheck(1'b0, NL'(1) << 7, "R4 collision");
    wrReg(1'b0, '0);
    rdCheck(1'b0, '0, "R3 clear all");

    // R5: enable readback
    wrReg(1'b1, 32'hDEAD_BEEF);
    rdCheck(1'b1, 32'hDEAD_BEEF, "R5 enable readback");
    wrReg(1'b1, '0);

    // R8: error line 17 halts channel 1 until cleared
    pulse(17);
    check("R8 halt raised", NL'(halt), NL'(ND'(1) << 1));
    repeat (5) step();
    check("R8 halt held", NL'(halt), NL'(ND'(1) << 1));
    wrReg(1'b0, ~(NL'(1) << 17));
    check("R8 halt released", NL'(halt), '0);

    // R9: informational line 16 never halts and refires
    pulse(16);
    check("R9 info no halt", NL'(halt), '0);
    rdCheck(1'b0, NL'(1) << 16, "R9 info latched");
    wrReg(1'b0, ~(NL'(1) << 16));
    rdCheck(1'b0, '0, "R9 info cleared");
    pulse(16);
    rdCheck(1'b0, NL'(1) << 16, "R9 info refires");
    wrReg(1'b0, '0);

    // R9: ordinary lines drive no halt
    reqV = 32'h0000_FFFF;
    step();
    reqV = '0;
    step();
    check("R9 ordinary no halt", NL'(halt), '0);
    wrReg(1'b0, '0);

    // R10: valid only in the cycle after the read
    rdEn = 1'b1; addr = 1'b0;
    step();
    rdEn = 1'b0;
    check("R10 valid after read", NL'(rdValid), NL'(1));
    step();
    check("R10 valid drops", NL'(rdValid), '0);

    // random mix, compared cycle by cycle
    for (int i = 0; i < 3000; i++) begin
      reqV  = reqV ^ ($urandom() & $urandom() & $urandom());
      wrEn  = ($urandom_range(0, 5) == 0);
      rdEn  = ($urandom_range(0, 2) == 0);
      addr  = 1'($urandom_range(0, 1));
      wdata = addr ? $urandom() : ~($urandom() & $urandom());
      step();
    end
    wrEn = 1'b0; rdEn = 1'b0; reqV = '0;
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule